// File: doc/BRIEF.md
# Big-Endian Load/Store Byte-Lane Unit

This block sits between the execute stage of a processor and a data memory whose words are 32 bits wide. On a store, it takes the access type and the low address bits and produces a per-byte write-enable mask. It also places the store data onto the byte lanes that the mask selects. On a load, it takes the word that memory returns one cycle after the address, picks out the addressed byte or halfword, and widens the value to a full word with either sign or zero fill.

Lane order is big-endian: byte offset 0 is the most significant byte of the word. The unit never splits an access that crosses a natural boundary. It raises a misalignment flag instead, and for such an access it drives no write enables and returns no load result. Write enables and write data are combinational from the request, so they travel with the address to memory. The load result is registered and appears two clock edges after the request.

Top module: `byte_lane_unit`

## Requirements
- R1: For byte loads, byte offset k selects memory bits [31-8k : 24-8k]. Offset 0 selects bits 31..24 and offset 3 selects bits 7..0.
- R2: The byte-load operation code 0 fills the upper 24 bits with bit 7 of the selected byte. Code 1 fills them with zeros.
- R3: A halfword load at offset 0 selects bits 31..16, and at offset 2 it selects bits 15..0. Code 2 sign-fills the upper 16 bits and code 3 zero-fills them.
- R4: A word load (code 4) at offset 0 returns the memory word unchanged.
- R5: A byte store (code 5) sets only write-enable bit (3 - offset) and copies store bits 7..0 onto all four lanes of the write data.
- R6: A halfword store (code 6) enables 4'b1100 at offset 0 or 4'b0011 at offset 2, and copies store bits 15..0 into both halves of the write data.
- R7: A word store (code 7) at offset 0 enables 4'b1111 and passes the store data through unchanged.
- R8: A halfword access at an odd offset, or a word access at any non-zero offset, raises `misalign` in the same cycle. Such an access drives an all-zero write mask and produces no load-valid pulse.
- R9: An aligned load presented before clock edge N gives `loadValid` high for exactly one cycle after edge N+1, with the result on `loadResult`. Memory read data is sampled in the cycle between those two edges.
- R10: After reset, `loadValid` and `loadResult` are zero. `loadResult` keeps its value in every cycle in which `loadValid` is low.
- R11: When `reqValid` is low, or the operation is a load, the write mask is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is present this cycle |
| reqOp | input | 3 | Access type: 0 LB, 1 LBU, 2 LH, 3 LHU, 4 LW, 5 SB, 6 SH, 7 SW |
| reqAddrLo | input | 2 | Byte offset of the address within the word |
| storeData | input | 32 | Register value to be stored |
| memRdata | input | 32 | Word returned by memory, one cycle after the request |
| memWe | output | 4 | Per-byte write enable, bit 3 is offset 0 |
| memWdata | output | 32 | Lane-aligned write data |
| misalign | output | 1 | Request breaks natural alignment |
| loadResult | output | 32 | Extended load value |
| loadValid | output | 1 | One-cycle pulse marking a new load result |

## Verification
The write path has no internal state, so a decode or lane error shows on `memWe` or `memWdata` in the same cycle as the request. A wrong pending offset, size or sign flag in the load pipeline shows only on the following `loadResult`, two edges after the request. A stuck or duplicated pending-valid bit shows as a missing or extra `loadValid` pulse, or as `loadResult` changing while `loadValid` is low. The bench therefore sweeps every operation, every offset and several data words with extreme sign bits. It checks each cycle around a request, not only the cycle in which the result is expected.

// File: rtl/lane_pkg.sv
package lane_pkg;

  localparam int BYTE_W = 8;

  // operation codes presented on reqOp
  typedef enum logic [2:0] {
    OP_LB  = 3'd0,
    OP_LBU = 3'd1,
    OP_LH  = 3'd2,
    OP_LHU = 3'd3,
    OP_LW  = 3'd4,
    OP_SB  = 3'd5,
    OP_SH  = 3'd6,
    OP_SW  = 3'd7
  } accOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     doLoad;
    logic     doStore;
    logic     misalign;
    accSize_e size;
    logic     signExt;
  } laneStrobe_t;

endpackage

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_pkg::*;
#(
  parameter int LANES = 4,
  parameter int OFF_W = $clog2(LANES)
) (
  input  logic             reqValid,
  input  logic [2:0]       reqOp,
  input  logic [OFF_W-1:0] reqOff,
  output laneStrobe_t      strobe,
  output logic [LANES-1:0] byteEn
);

  accOp_e   op;
  accSize_e size;
  logic     isLoadOp;
  logic     isStoreOp;
  logic     signExt;
  logic     badAlign;

  assign op = accOp_e'(reqOp);

  always_comb begin
    isLoadOp  = 1'b0;
    isStoreOp = 1'b0;
    signExt   = 1'b0;
    size      = SZ_WORD;
    case (op)
      OP_LB:   begin isLoadOp  = 1'b1; signExt = 1'b1; size = SZ_BYTE; end
      OP_LBU:  begin isLoadOp  = 1'b1; size = SZ_BYTE; end
      OP_LH:   begin isLoadOp  = 1'b1; signExt = 1'b1; size = SZ_HALF; end
      OP_LHU:  begin isLoadOp  = 1'b1; size = SZ_HALF; end
      OP_LW:   begin isLoadOp  = 1'b1; size = SZ_WORD; end
      OP_SB:   begin isStoreOp = 1'b1; size = SZ_BYTE; end
      OP_SH:   begin isStoreOp = 1'b1; size = SZ_HALF; end
      OP_SW:   begin isStoreOp = 1'b1; size = SZ_WORD; end
      default: begin isLoadOp  = 1'b0; end
    endcase
  end

  // natural alignment: halfword needs offset bit 0 clear, word needs all clear
  always_comb begin
    case (size)
      SZ_HALF: badAlign = reqOff[0];
      SZ_WORD: badAlign = |reqOff;
      default: badAlign = 1'b0;
    endcase
  end

  assign strobe.doLoad   = reqValid & isLoadOp;
  assign strobe.doStore  = reqValid & isStoreOp;
  assign strobe.misalign = reqValid & badAlign;
  assign strobe.size     = size;
  assign strobe.signExt  = signExt;

  // byte-enable bit i belongs to big-endian offset LANES-1-i
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFF_W-1:0] LANE_OFF = OFF_W'(LANES - 1 - i);
    logic hitByte;
    logic hitHalf;
    logic laneHit;
    assign hitByte = (reqOff == LANE_OFF);
    assign hitHalf = ((reqOff >> 1) == (LANE_OFF >> 1));
    always_comb begin
      case (size)
        SZ_BYTE: laneHit = hitByte;
        SZ_HALF: laneHit = hitHalf;
        default: laneHit = 1'b1;
      endcase
    end
    assign byteEn[i] = strobe.doStore & ~badAlign & laneHit;
  end

endmodule

// File: rtl/lane_datapath.sv
module lane_datapath
  import lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobe_t       strobe,
  input  logic [OFF_W-1:0]  reqOff,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] loadResult,
  output logic              loadValid
);

  localparam int LANES  = DATA_W / BYTE_W;
  localparam int HALF_W = 2 * BYTE_W;
  localparam int HALVES = LANES / 2;

  // store side: replicate the narrow value across the word
  logic [DATA_W-1:0] byteRep;
  logic [DATA_W-1:0] halfRep;

  for (genvar g = 0; g < LANES; g++) begin : g_byteRep
    assign byteRep[g*BYTE_W +: BYTE_W] = storeData[BYTE_W-1:0];
  end
  for (genvar h = 0; h < HALVES; h++) begin : g_halfRep
    assign halfRep[h*HALF_W +: HALF_W] = storeData[HALF_W-1:0];
  end

  always_comb begin
    case (strobe.size)
      SZ_BYTE: memWdata = byteRep;
      SZ_HALF: memWdata = halfRep;
      default: memWdata = storeData;
    endcase
  end

  // load side, stage 1: remember the request while memory responds
  logic             pendValid;
  logic [OFF_W-1:0] pendOff;
  accSize_e         pendSize;
  logic             pendSign;
  logic             launch;

  assign launch = strobe.doLoad & ~strobe.misalign;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendOff   <= '0;
      pendSize  <= SZ_WORD;
      pendSign  <= 1'b0;
    end else begin
      pendValid <= launch;
      if (launch) begin
        pendOff  <= reqOff;
        pendSize <= strobe.size;
        pendSign <= strobe.signExt;
      end
    end
  end

  // load side, stage 2: pick lanes in big-endian order and extend
  logic [BYTE_W-1:0] byteLane [LANES];
  logic [HALF_W-1:0] halfLane [HALVES];

  for (genvar k = 0; k < LANES; k++) begin : g_byteLane
    assign byteLane[k] = memRdata[DATA_W-1-k*BYTE_W -: BYTE_W];
  end
  for (genvar k = 0; k < HALVES; k++) begin : g_halfLane
    assign halfLane[k] = memRdata[DATA_W-1-k*HALF_W -: HALF_W];
  end

  logic [BYTE_W-1:0] pickByte;
  logic [HALF_W-1:0] pickHalf;
  logic [DATA_W-1:0] extracted;

  assign pickByte = byteLane[pendOff];
  assign pickHalf = halfLane[pendOff[OFF_W-1:1]];

  always_comb begin
    case (pendSize)
      SZ_BYTE: extracted = {{(DATA_W-BYTE_W){pendSign & pickByte[BYTE_W-1]}}, pickByte};
      SZ_HALF: extracted = {{(DATA_W-HALF_W){pendSign & pickHalf[HALF_W-1]}}, pickHalf};
      default: extracted = memRdata;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadValid  <= 1'b0;
      loadResult <= '0;
    end else begin
      loadValid <= pendValid;
      if (pendValid) begin
        loadResult <= extracted;
      end
    end
  end

endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit
  import lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  input  logic [2:0]                    reqOp,
  input  logic [$clog2(DATA_W/8)-1:0]   reqAddrLo,
  input  logic [DATA_W-1:0]             storeData,
  input  logic [DATA_W-1:0]             memRdata,
  output logic [DATA_W/8-1:0]           memWe,
  output logic [DATA_W-1:0]             memWdata,
  output logic                          misalign,
  output logic [DATA_W-1:0]             loadResult,
  output logic                          loadValid
);

  localparam int LANES = DATA_W / BYTE_W;
  localparam int OFF_W = $clog2(LANES);

  laneStrobe_t strobe;

  lane_ctrl #(
    .LANES (LANES),
    .OFF_W (OFF_W)
  ) i_ctrl (
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .reqOff   (reqAddrLo),
    .strobe   (strobe),
    .byteEn   (memWe)
  );

  lane_datapath #(
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqOff     (reqAddrLo),
    .storeData  (storeData),
    .memRdata   (memRdata),
    .memWdata   (memWdata),
    .loadResult (loadResult),
    .loadValid  (loadValid)
  );

  assign misalign = strobe.misalign;

endmodule

// File: rtl/byte_lane_unit_chk.sv
module byte_lane_unit_chk
  import lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        reqValid,
  input logic [2:0]                  reqOp,
  input logic [$clog2(DATA_W/8)-1:0] reqAddrLo,
  input logic [DATA_W-1:0]           storeData,
  input logic [DATA_W/8-1:0]         memWe,
  input logic [DATA_W-1:0]           memWdata,
  input logic                        misalign,
  input logic [DATA_W-1:0]           loadResult,
  input logic                        loadValid
);

  assert_byte_store_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_SB) |-> ($countones(memWe) == 1));

  assert_half_store_pair_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_SH && !reqAddrLo[0]) |-> ($countones(memWe) == 2));

  assert_word_store_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == OP_SW && reqAddrLo == '0) |-> (&memWe && memWdata == storeData));

  assert_misalign_no_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    misalign |-> (memWe == '0));

  assert_word_offset_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (reqOp == OP_SW || reqOp == OP_LW) && reqAddrLo != '0) |-> misalign);

  assert_load_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp <= OP_LW && !misalign) |=> ##1 loadValid);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !loadValid |-> $stable(loadResult));

  assert_idle_no_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid || reqOp <= OP_LW) |-> (memWe == '0));

endmodule

bind byte_lane_unit byte_lane_unit_chk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_byte_lane_unit.sv
`timescale 1ns/1ps
module test_byte_lane_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  reqOp = 3'd0;
  logic [1:0]  reqAddrLo = 2'd0;
  logic [31:0] storeData = '0;
  logic [31:0] memRdata = '0;
  logic [3:0]  memWe;
  logic [31:0] memWdata;
  logic        misalign;
  logic [31:0] loadResult;
  logic        loadValid;

  int checks = 0;
  int bads = 0;
  bit finished = 1'b0;
  logic [31:0] heldResult = '0;

  always #10 clk = ~clk;

  byte_lane_unit i_byte_lane_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddrLo(reqAddrLo), .storeData(storeData), .memRdata(memRdata),
    .memWe(memWe), .memWdata(memWdata), .misalign(misalign),
    .loadResult(loadResult), .loadValid(loadValid)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bads++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expLoad(input logic [2:0] op, input logic [1:0] off, input logic [31:0] w);
    logic [7:0]  b;
    logic [15:0] h;
    b = w[8*(3-int'(off)) +: 8];
    h = w[16*(1-int'(off[1])) +: 16];
    case (op)
      3'd0:    return b[7] ? {24'hFFFFFF, b} : {24'h0, b};
      3'd1:    return {24'h0, b};
      3'd2:    return h[15] ? {16'hFFFF, h} : {16'h0, h};
      3'd3:    return {16'h0, h};
      default: return w;
    endcase
  endfunction

  task automatic runReq(input logic [2:0] op, input logic [1:0] off, input logic [31:0] sd, input logic [31:0] word);
    bit isLoad, ma;
    logic [3:0]  expWe;
    logic [31:0] expWd;
    logic [31:0] expRes;
    string tag;
    isLoad = (op <= 3'd4);
    ma = ((op == 3'd2 || op == 3'd3 || op == 3'd6) && off[0]) ||
         ((op == 3'd4 || op == 3'd7) && off != 2'd0);
    expWe = 4'b0000;
    expWd = sd;
    case (op)
      3'd5: begin expWe = 4'b1000 >> off; expWd = 32'h01010101 * {24'h0, sd[7:0]}; tag = "R5 byte store"; end
      3'd6: begin expWe = (off == 2'd0) ? 4'b1100 : 4'b0011; expWd = 32'h00010001 * {16'h0, sd[15:0]}; tag = "R6 half store"; end
      3'd7: begin expWe = 4'b1111; tag = "R7 word store"; end
      3'd0, 3'd1: tag = "R1 R2 byte load";
      3'd2, 3'd3: tag = "R3 half load";
      default: tag = "R4 word load";
    endcase
    if (ma) begin
      expWe = 4'b0000;
      tag = "R8 misaligned";
    end
    expRes = expLoad(op, off, word);

    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddrLo = off; storeData = sd;
    #1;
    check(misalign == ma, "R8 misalign flag", {31'h0, misalign}, {31'h0, ma});
    if (isLoad) check(memWe == 4'b0000, "R11 no write on load", {28'h0, memWe}, 32'h0);
    else check(memWe == expWe, tag, {28'h0, memWe}, {28'h0, expWe});
    if (!isLoad && !ma) check(memWdata == expWd, tag, memWdata, expWd);

    @(negedge clk);
    reqValid = 1'b0; memRdata = word;
    #1;
    check(loadValid == 1'b0, "R9 early valid", {31'h0, loadValid}, 32'h0);

    @(negedge clk);
    #1;
    if (isLoad && !ma) begin
      check(loadValid == 1'b1, "R9 valid pulse", {31'h0, loadValid}, 32'h1);
      check(loadResult == expRes, tag, loadResult, expRes);
      heldResult = expRes;
    end else begin
      check(loadValid == 1'b0, ma ? "R8 no load pulse" : "R11 no load pulse", {31'h0, loadValid}, 32'h0);
    end
    memRdata = ~word;

    @(negedge clk);
    #1;
    check(loadValid == 1'b0, "R9 single pulse", {31'h0, loadValid}, 32'h0);
    check(loadResult == heldResult, "R10 result held", loadResult, heldResult);
  endtask

  logic [31:0] pats [4] = '{32'h80FF7F01, 32'h7F0180FE, 32'hA5C33C5A, 32'h01234567};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(loadValid == 1'b0, "R10 reset valid", {31'h0, loadValid}, 32'h0);
    check(loadResult == 32'h0, "R10 reset result", loadResult, 32'h0);
    check(memWe == 4'b0000, "R10 reset write mask", {28'h0, memWe}, 32'h0);

    @(negedge clk);
    reqValid = 1'b0; reqOp = 3'd7; reqAddrLo = 2'd0; storeData = 32'hDEADBEEF;
    #1;
    check(memWe == 4'b0000, "R11 idle store", {28'h0, memWe}, 32'h0);
    check(misalign == 1'b0, "R11 idle flag", {31'h0, misalign}, 32'h0);

    for (int p = 0; p < 4; p++) begin
      for (int o = 0; o < 8; o++) begin
        for (int a = 0; a < 4; a++) begin
          runReq(3'(o), 2'(a), pats[(p + 1) % 4], pats[p]);
        end
      end
    end

    $display("test done: total=%0d bad=%0d", checks, bads);
    finished = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bads++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", checks, bads);
      $finish;
    end
  end

endmodule